// File: doc/BRIEF.md
# Pipeline Exception Controller

This unit decides when an in-order pipeline leaves its normal instruction flow for an exception handler and when it comes back. It looks at the instruction sitting at the commit point, which is the execute stage. That instruction may raise a synchronous trap: an undefined opcode or an arithmetic overflow. It may instead be a return-from-exception. The unit also samples an asynchronous external interrupt line. When an exception is taken, the unit does five things in one clock edge: it writes a cause code, stores the PC of the committing instruction, switches to kernel mode with interrupts masked, flushes the committing instruction and every younger one, and steers fetch to a fixed handler vector.

The status state holds the current mode and interrupt enable. It also holds a one-level copy of their previous values. Entry shifts the current values into that copy. A return copies them back in the same cycle that fetch is sent to the saved PC, so mode and enable never change on different edges. The unit owns the fetch PC register. When there is no redirect, the register follows the sequential or branch address that the pipeline offers. The general return-address register is never touched.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, kernel_mode_o=1, int_enable_o=0, cause_o=0, epc_o=0 and fetch_pc_o=0. The saved copy holds user mode with interrupts enabled (prev_kernel_o=0, prev_int_enable_o=1), so the first return drops to user mode with interrupts on.
- R2: A trap on a valid commit raises flush_o and exc_taken_o in that same cycle. On the next edge fetch_pc_o becomes VEC (default 0xC00) and epc_o becomes the commit PC.
- R3: cause_o is written as 0 for an undefined instruction, 1 for arithmetic overflow and 2 for an external interrupt. If both trap flags are set, undefined (0) wins.
- R4: On every exception entry, kernel_mode_o becomes 1 and int_enable_o becomes 0. prev_kernel_o and prev_int_enable_o take the values that were current before the entry.
- R5: A return on a valid commit raises flush_o. On the next edge kernel_mode_o and int_enable_o load the saved copy and fetch_pc_o loads epc_o. cause_o and epc_o do not change.
- R6: A cycle with irq_i=1 sets irq_pending_o, which stays set after irq_i drops. The interrupt is taken, with cause 2, on the next valid commit with int_enable_o=1. It is never taken while int_enable_o=0.
- R7: If a trap and a pending interrupt meet in one commit, the trap is taken and irq_pending_o stays 1.
- R8: With commit_valid_i=0, the trap and return flags have no effect: no flush, no status change, and fetch follows pc_seq_i.
- R9: In a cycle with no exception and no return, fetch_pc_o loads pc_seq_i on the next edge.
- R10: A return and a pending interrupt in one commit: the return is performed and irq_pending_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_valid_i | input | 1 | A real instruction occupies the commit point |
| commit_pc_i | input | AW | PC of the committing instruction |
| trap_undef_i | input | 1 | Committing instruction has an undefined opcode |
| trap_ovf_i | input | 1 | Committing instruction overflowed |
| eret_i | input | 1 | Committing instruction is a return-from-exception |
| irq_i | input | 1 | External interrupt request level |
| pc_seq_i | input | AW | Pipeline's next fetch address when not redirected |
| fetch_pc_o | output | AW | Fetch PC register |
| flush_o | output | 1 | Kill the committing instruction and all younger stages |
| exc_taken_o | output | 1 | An exception is entered this cycle |
| kernel_mode_o | output | 1 | 1 = kernel mode |
| int_enable_o | output | 1 | Interrupt enable |
| prev_kernel_o | output | 1 | Saved mode copy |
| prev_int_enable_o | output | 1 | Saved interrupt-enable copy |
| irq_pending_o | output | 1 | Latched interrupt awaiting acceptance |
| cause_o | output | CAUSE_W | Exception code |
| epc_o | output | AW | Saved exception PC |

## Verification
The assertions take for granted that trap flags and the return flag mean something only while commit_valid_i is high. They also assume that a committing instruction is not both a trap and a return in any way that matters, since a trap simply takes priority. The stimulus raises the flags with commit_valid_i low only in the cycles that deliberately test R8. It pulses irq_i for single cycles, so acceptance depends on the latched pending bit and not on the line staying high. Same-cycle collisions of trap with interrupt and of return with interrupt are set up on purpose, and the bench model applies trap, then return, then interrupt priority on its own.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

  typedef enum logic [1:0] {
    CODE_UNDEF = 2'd0,
    CODE_OVF   = 2'd1,
    CODE_IRQ   = 2'd2
  } exc_code_e;

  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_VEC = 2'd1,
    NPC_EPC = 2'd2
  } npc_sel_e;

  typedef struct packed {
    logic kernel;
    logic ie;
  } mode_t;

  // Trap code: undefined opcode has precedence over overflow.
  function automatic exc_code_e trap_code(input logic undef);
    return undef ? CODE_UNDEF : CODE_OVF;
  endfunction

  // Choose the fetch source: entry beats return beats sequential.
  function automatic npc_sel_e npc_select(input logic enter, input logic leave);
    if (enter)      return NPC_VEC;
    else if (leave) return NPC_EPC;
    else            return NPC_SEQ;
  endfunction

  // Mode after entry: kernel, interrupts masked.
  function automatic mode_t entry_mode();
    mode_t m;
    m.kernel = 1'b1;
    m.ie     = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      commit_valid,
  input  logic      trap_undef,
  input  logic      trap_ovf,
  input  logic      eret,
  input  logic      irq,
  input  logic      ie,
  output logic      trap_take,
  output logic      irq_take,
  output logic      eret_take,
  output logic      irq_pend,
  output exc_code_e code
);

  logic pend_q;
  logic trap_req;

  assign trap_req  = commit_valid & (trap_undef | trap_ovf);
  assign trap_take = trap_req;
  assign eret_take = commit_valid & eret & ~trap_req;
  assign irq_take  = commit_valid & pend_q & ie & ~trap_req & ~eret_take;

  always_comb begin
    if (trap_req) code = trap_code(trap_undef);
    else          code = CODE_IRQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q | irq) & ~irq_take;
  end

  assign irq_pend = pend_q;

endmodule

// File: rtl/exc_status.sv
module exc_status
  import exc_ctrl_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enter,
  input  logic               leave,
  input  exc_code_e          code,
  input  logic [AW-1:0]      commit_pc,
  output mode_t              cur,
  output mode_t              prev,
  output logic [CAUSE_W-1:0] cause,
  output logic [AW-1:0]      epc
);

  localparam int PAD_W = CAUSE_W - 2;

  mode_t              cur_q, prev_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [AW-1:0]      epc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= entry_mode();
      prev_q  <= '{kernel: 1'b0, ie: 1'b1};
      cause_q <= '0;
      epc_q   <= '0;
    end else if (enter) begin
      prev_q  <= cur_q;
      cur_q   <= entry_mode();
      cause_q <= {{PAD_W{1'b0}}, code};
      epc_q   <= commit_pc;
    end else if (leave) begin
      cur_q   <= prev_q;
    end
  end

  assign cur   = cur_q;
  assign prev  = prev_q;
  assign cause = cause_q;
  assign epc   = epc_q;

endmodule

// File: rtl/exc_fetch_pc.sv
module exc_fetch_pc
  import exc_ctrl_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC      = 'hC00,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter,
  input  logic          leave,
  input  logic [AW-1:0] epc,
  input  logic [AW-1:0] pc_seq,
  output logic [AW-1:0] fetch_pc
);

  npc_sel_e      sel;
  logic [AW-1:0] npc;

  assign sel = npc_select(enter, leave);

  always_comb begin
    case (sel)
      NPC_VEC: npc = VEC;
      NPC_EPC: npc = epc;
      default: npc = pc_seq;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_pc <= RESET_PC;
    else        fetch_pc <= npc;
  end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            CAUSE_W  = 4,
  parameter logic [AW-1:0] VEC      = 'hC00,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_valid_i,
  input  logic [AW-1:0]      commit_pc_i,
  input  logic               trap_undef_i,
  input  logic               trap_ovf_i,
  input  logic               eret_i,
  input  logic               irq_i,
  input  logic [AW-1:0]      pc_seq_i,
  output logic [AW-1:0]      fetch_pc_o,
  output logic               flush_o,
  output logic               exc_taken_o,
  output logic               kernel_mode_o,
  output logic               int_enable_o,
  output logic               prev_kernel_o,
  output logic               prev_int_enable_o,
  output logic               irq_pending_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [AW-1:0]      epc_o
);

  // Named internal events
  logic      trap_take, irq_take, eret_take, irq_pend;
  logic      enter;
  exc_code_e code;
  mode_t     cur, prev;

  exc_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_valid (commit_valid_i),
    .trap_undef   (trap_undef_i),
    .trap_ovf     (trap_ovf_i),
    .eret         (eret_i),
    .irq          (irq_i),
    .ie           (cur.ie),
    .trap_take    (trap_take),
    .irq_take     (irq_take),
    .eret_take    (eret_take),
    .irq_pend     (irq_pend),
    .code         (code)
  );

  assign enter = trap_take | irq_take;

  exc_status #(.AW(AW), .CAUSE_W(CAUSE_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter     (enter),
    .leave     (eret_take),
    .code      (code),
    .commit_pc (commit_pc_i),
    .cur       (cur),
    .prev      (prev),
    .cause     (cause_o),
    .epc       (epc_o)
  );

  exc_fetch_pc #(.AW(AW), .VEC(VEC), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter    (enter),
    .leave    (eret_take),
    .epc      (epc_o),
    .pc_seq   (pc_seq_i),
    .fetch_pc (fetch_pc_o)
  );

  assign flush_o           = enter | eret_take;
  assign exc_taken_o       = enter;
  assign kernel_mode_o     = cur.kernel;
  assign int_enable_o      = cur.ie;
  assign prev_kernel_o     = prev.kernel;
  assign prev_int_enable_o = prev.ie;
  assign irq_pending_o     = irq_pend;

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int            AW      = 32,
  parameter int            CAUSE_W = 4,
  parameter logic [AW-1:0] VEC     = 'hC00
) (
  input logic               clk,
  input logic               rst_n,
  input logic               commit_valid_i,
  input logic [AW-1:0]      commit_pc_i,
  input logic               trap_undef_i,
  input logic               trap_take,
  input logic               irq_take,
  input logic               eret_take,
  input logic               flush_o,
  input logic               exc_taken_o,
  input logic               kernel_mode_o,
  input logic               int_enable_o,
  input logic               prev_kernel_o,
  input logic               prev_int_enable_o,
  input logic               irq_pending_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [AW-1:0]      epc_o,
  input logic [AW-1:0]      fetch_pc_o
);

  assert_trap_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> flush_o);

  assert_vector_epc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken_o |=> (fetch_pc_o == VEC) && (epc_o == $past(commit_pc_i)));

  assert_undef_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && trap_undef_i) |=> (cause_o == '0));

  assert_entry_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken_o |=> kernel_mode_o && !int_enable_o &&
                    (prev_kernel_o == $past(kernel_mode_o)) &&
                    (prev_int_enable_o == $past(int_enable_o)));

  assert_return_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eret_take |=> (kernel_mode_o == $past(prev_kernel_o)) &&
                  (int_enable_o == $past(prev_int_enable_o)) &&
                  (fetch_pc_o == $past(epc_o)) && $stable(cause_o));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> int_enable_o);

  assert_trap_keeps_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && irq_pending_o) |=> irq_pending_o);

  assert_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_valid_i |-> !flush_o);

  assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_take, irq_take, eret_take}));

endmodule

bind exc_ctrl exc_ctrl_chk #(.AW(AW), .CAUSE_W(CAUSE_W), .VEC(VEC)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .commit_valid_i    (commit_valid_i),
  .commit_pc_i       (commit_pc_i),
  .trap_undef_i      (trap_undef_i),
  .trap_take         (trap_take),
  .irq_take          (irq_take),
  .eret_take         (eret_take),
  .flush_o           (flush_o),
  .exc_taken_o       (exc_taken_o),
  .kernel_mode_o     (kernel_mode_o),
  .int_enable_o      (int_enable_o),
  .prev_kernel_o     (prev_kernel_o),
  .prev_int_enable_o (prev_int_enable_o),
  .irq_pending_o     (irq_pending_o),
  .cause_o           (cause_o),
  .epc_o             (epc_o),
  .fetch_pc_o        (fetch_pc_o)
);

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam logic [AW-1:0] VEC = 32'hC00;

  logic clk = 0, rst_n = 0;
  logic commit_valid_i = 0, trap_undef_i = 0, trap_ovf_i = 0, eret_i = 0, irq_i = 0;
  logic [AW-1:0] commit_pc_i = 0, pc_seq_i = 0;
  logic [AW-1:0] fetch_pc_o, epc_o;
  logic flush_o, exc_taken_o, kernel_mode_o, int_enable_o;
  logic prev_kernel_o, prev_int_enable_o, irq_pending_o;
  logic [CW-1:0] cause_o;

  exc_ctrl u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;

  typedef struct {
    string req;
    logic [AW-1:0] pc, epc;
    logic k, ie, pk, pie, pend;
    logic [CW-1:0] cause;
  } exp_t;
  exp_t q[$];

  // Bench model state
  logic [AW-1:0] m_pc = 0, m_epc = 0;
  logic m_k = 1, m_ie = 0, m_pk = 0, m_pie = 1, m_pend = 0;
  logic [CW-1:0] m_cause = 0;

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(string req, logic v, logic u, logic o, logic e, logic irq);
    logic trap, ret, take, enter;
    exp_t x;
    @(negedge clk);
    commit_valid_i = v; trap_undef_i = u; trap_ovf_i = o; eret_i = e; irq_i = irq;
    commit_pc_i = m_pc - 32'd8;
    pc_seq_i = m_pc + 32'd4;
    trap = v && (u || o);
    ret  = v && e && !trap;
    take = v && m_pend && m_ie && !trap && !ret;
    enter = trap || take;
    #1;
    chk({req, " flush"}, {31'b0, flush_o}, {31'b0, enter || ret});
    chk({req, " taken"}, {31'b0, exc_taken_o}, {31'b0, enter});
    if (enter) begin
      m_pk = m_k; m_pie = m_ie; m_k = 1; m_ie = 0;
      m_cause = trap ? (u ? 4'd0 : 4'd1) : 4'd2;
      m_epc = commit_pc_i;
      m_pc = VEC;
    end else if (ret) begin
      m_k = m_pk; m_ie = m_pie;
      m_pc = m_epc;
    end else begin
      m_pc = pc_seq_i;
    end
    m_pend = (m_pend || irq) && !take;
    x.req = req; x.pc = m_pc; x.epc = m_epc; x.k = m_k; x.ie = m_ie;
    x.pk = m_pk; x.pie = m_pie; x.pend = m_pend; x.cause = m_cause;
    q.push_back(x);
  endtask

  // Monitor: compare registered outputs just after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk({x.req, " fetch_pc"}, fetch_pc_o, x.pc);
      chk({x.req, " epc"}, epc_o, x.epc);
      chk({x.req, " cause"}, {28'b0, cause_o}, {28'b0, x.cause});
      chk({x.req, " mode"}, {30'b0, kernel_mode_o, int_enable_o}, {30'b0, x.k, x.ie});
      chk({x.req, " prev"}, {30'b0, prev_kernel_o, prev_int_enable_o}, {30'b0, x.pk, x.pie});
      chk({x.req, " pend"}, {31'b0, irq_pending_o}, {31'b0, x.pend});
    end
  end

  initial begin
    #(CLK_PERIOD * 2000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    // R1 reset state
    chk("R1 fetch_pc", fetch_pc_o, 0);
    chk("R1 mode", {30'b0, kernel_mode_o, int_enable_o}, {30'b0, 2'b10});
    chk("R1 prev", {30'b0, prev_kernel_o, prev_int_enable_o}, {30'b0, 2'b01});
    chk("R1 cause", {28'b0, cause_o}, 0);
    chk("R1 epc", epc_o, 0);
    rst_n = 1;
    step("R9 seq", 1, 0, 0, 0, 0);
    step("R9 seq", 1, 0, 0, 0, 0);
    step("R8 novalid", 0, 1, 1, 1, 0);
    step("R5 eret to user", 1, 0, 0, 1, 0);
    step("R9 seq", 1, 0, 0, 0, 0);
    step("R2 ovf trap", 1, 0, 1, 0, 0);
    step("R4 after entry", 1, 0, 0, 0, 0);
    step("R5 eret", 1, 0, 0, 1, 0);
    step("R3 undef wins", 1, 1, 1, 0, 0);
    step("R5 eret", 1, 0, 0, 1, 0);
    step("R6 irq latch", 0, 0, 0, 0, 1);
    step("R6 irq taken", 1, 0, 0, 0, 0);
    step("R6 irq masked", 0, 0, 0, 0, 1);
    step("R6 irq masked", 1, 0, 0, 0, 0);
    step("R6 irq masked", 1, 0, 0, 0, 0);
    step("R10 eret vs irq", 1, 0, 0, 1, 0);
    step("R6 irq later", 1, 0, 0, 0, 0);
    step("R5 eret", 1, 0, 0, 1, 0);
    step("R7 irq latch", 0, 0, 0, 0, 1);
    step("R7 trap vs irq", 1, 0, 1, 0, 0);
    step("R7 pending kept", 1, 0, 0, 0, 0);
    step("R5 eret", 1, 0, 0, 1, 0);
    step("R7 irq after", 1, 0, 0, 0, 0);
    step("R8 novalid", 0, 0, 1, 0, 0);
    step("R8 novalid", 0, 0, 0, 1, 0);
    step("R9 seq", 1, 0, 0, 0, 0);
    @(negedge clk);
    commit_valid_i = 0; trap_undef_i = 0; trap_ovf_i = 0; eret_i = 0; irq_i = 0;
    @(posedge clk); #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule